// File: doc/BRIEF.md
# Serial ADC Conversion Readout Controller

This block runs the digital side of a fast ADC with a serial output. It starts a conversion once per sample period, which is set at run time as a number of clock cycles. It then sends a gated burst of read clocks to shift out one 16-bit result. The serial bits are packed into a parallel word. The word leaves the block with a one-cycle valid strobe and a tag giving the index of the conversion that produced it.

After each conversion start, the converter has a window in which its output register may be changing. No read clock edge may be issued there. The window opens once the clock-low limit has passed and closes once the data-ready delay has passed. The ready delay is a worst-case time in picoseconds, rounded up to whole design clock cycles. Two read placements avoid the window, and a mode input chooses between them. An early burst right after the conversion start returns the previous conversion. A late burst after the ready delay returns the conversion just started.

If the configured period cannot hold the chosen placement, a configuration-error flag is raised and no conversion is started. Mode and period are sampled at each conversion start, so a change during a period takes effect from the next one.

Top module: `adc_readout_ctrl`

## Requirements
- R1: `cnv_o` rises in the first cycle of each sample period and stays high for CNV_W cycles. While enabled and correctly configured, the next rise comes exactly the latched period (in cycles) later.
- R2: Let the cycle in which `cnv_o` rises be t=0. No rising edge of `rd_clk_o` falls at a t with CLKL_CYC <= t < READY_CYC, where READY_CYC = ceil(READY_PS / TCLK_PS).
- R3: In late mode (`mode_i`=1), `rd_clk_o` is high first at t=READY_CYC. It then runs 16 periods of HALF_CYC cycles high and HALF_CYC cycles low. It is low in every other cycle.
- R4: In early mode (`mode_i`=0), the same 16-period burst starts at t=1, and `rd_clk_o` is low outside the burst.
- R5: Bit j of the burst (j=0 first) is sampled in the cycle at offset HALF_CYC/2 inside the high phase of read clock period j. It is placed at word bit 15-j, so the word is filled MSB first.
- R6: `valid_o` is high for exactly one cycle per burst, in the cycle after the last bit is sampled, and `word_o` holds the assembled word in that cycle.
- R7: Conversions are numbered from 0 after reset, modulo 2^IDX_W. In late mode `tag_o` is the number of the conversion in the current period. In early mode it is that number minus one, so the first early read after reset is tagged 255.
- R8: Late mode fits when period >= READY_CYC + 32*HALF_CYC. Early mode fits when period >= READY_CYC and 1 + 32*HALF_CYC <= CLKL_CYC. `cfg_err_o` shows the misfit of the inputs seen at the previous clock edge, and no conversion starts while the inputs misfit.
- R9: `mode_i` and `period_i` are sampled only when a conversion starts. A change during a period alters neither that period's burst nor its length.
- R10: While `enable_i` is low no new conversion starts, but a period already running completes, burst and valid strobe included.
- R11: During reset `cnv_o`, `rd_clk_o`, `valid_o` and `cfg_err_o` are low, and `word_o` and `tag_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows new conversions to start |
| mode_i | input | 1 | 0: early read (previous sample), 1: late read (current sample) |
| period_i | input | CNT_W | Sample period in clock cycles |
| sdata_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Conversion-start strobe |
| rd_clk_o | output | 1 | Gated read clock, idles low |
| word_o | output | DATA_W | Assembled conversion word |
| tag_o | output | IDX_W | Index of the conversion the word belongs to |
| valid_o | output | 1 | One-cycle strobe marking a new word |
| cfg_err_o | output | 1 | Period or timing does not fit the chosen mode |

## Verification
The hardest case to reach is a mode or period change in the middle of a running period, because the new values must be ignored until the next start. Random segments of settings change at arbitrary cycles, and a directed case switches mode and stretches the period just after a late-mode start. The check is that the valid strobe still lands at the late-mode position and the old period length still holds. A converter model in the bench picks the previous or the current sample from when each burst actually begins. A read inside the quiet window yields a marker word and a failed check, independent of the expected-value model.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    // Read placement relative to the conversion start
    typedef enum logic {
        RD_EARLY = 1'b0,   // burst right after start, previous result
        RD_LATE  = 1'b1    // burst after the ready delay, current result
    } rd_mode_e;

    // Round a picosecond delay up to whole clock cycles
    function automatic int unsigned ps_to_cyc(input int unsigned dly_ps,
                                              input int unsigned clk_ps);
        return (dly_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/adc_rd_seq.sv
// Sample-period sequencer: conversion start, period counter, conversion index,
// configuration fit check.
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int IDX_W    = 8,
    parameter int CNV_W    = 2,
    parameter int MIN_EARLY = 73,
    parameter int MIN_LATE  = 105,
    parameter bit EARLY_OK  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  rd_mode_e         mode_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] t_o,
    output logic             wrap_o,
    output logic             active_o,
    output rd_mode_e         mode_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             cnv_o,
    output logic             cfg_err_o
);

    localparam logic [CNT_W-1:0] MIN_E_C = CNT_W'(MIN_EARLY);
    localparam logic [CNT_W-1:0] MIN_L_C = CNT_W'(MIN_LATE);
    localparam logic [CNT_W-1:0] CNV_LIM = CNT_W'(CNV_W);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] t;
        logic [CNT_W-1:0] per;
        rd_mode_e         mode;
        logic [IDX_W-1:0] cur;
        logic [IDX_W-1:0] nxt;
        logic             cnv;
        logic             err;
    } seq_t;

    seq_t st_q, st_d;
    logic fit, wrap, start;

    always_comb begin
        st_d  = st_q;
        fit   = (mode_i == RD_LATE) ? (period_i >= MIN_L_C)
                                    : (EARLY_OK && (period_i >= MIN_E_C));
        wrap  = st_q.active && (st_q.t == st_q.per - ONE_C);
        start = (!st_q.active || wrap) && enable_i && fit;

        if (start) begin
            st_d.active = 1'b1;
            st_d.t      = '0;
            st_d.per    = period_i;
            st_d.mode   = mode_i;
            st_d.cur    = st_q.nxt;
            st_d.nxt    = st_q.nxt + IDX_W'(1);
        end else if (wrap) begin
            st_d.active = 1'b0;
            st_d.t      = '0;
        end else if (st_q.active) begin
            st_d.t      = st_q.t + ONE_C;
        end

        st_d.cnv = st_d.active && (st_d.t < CNV_LIM);
        st_d.err = !fit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign t_o       = st_q.t;
    assign wrap_o    = wrap;
    assign active_o  = st_q.active;
    assign mode_o    = st_q.mode;
    assign idx_o     = st_q.cur;
    assign cnv_o     = st_q.cnv;
    assign cfg_err_o = st_q.err;

endmodule

// File: rtl/adc_rd_burst.sv
// Read-clock burst generator. Decides from the current period position what the
// registered read clock and capture strobe are in the following cycle.
module adc_rd_burst
    import adc_rd_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int DATA_W      = 16,
    parameter int HALF_CYC    = 1,
    parameter int EARLY_START = 1,
    parameter int LATE_START  = 73
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] t_i,
    input  logic             wrap_i,
    input  logic             active_i,
    input  rd_mode_e         mode_i,
    output logic             rd_clk_o,
    output logic             cap_o,
    output logic             lastbit_o
);

    localparam int PER2     = 2 * HALF_CYC;
    localparam int BURST    = PER2 * DATA_W;
    localparam int CAP_OFF  = HALF_CYC / 2;
    localparam bit PER2_P2  = ((PER2 & (PER2 - 1)) == 0);

    localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST);
    localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(HALF_CYC);
    localparam logic [CNT_W-1:0] CAP_C   = CNT_W'(CAP_OFF);
    localparam logic [CNT_W-1:0] LASTB_C = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] E_ST_C  = CNT_W'(EARLY_START);
    localparam logic [CNT_W-1:0] L_ST_C  = CNT_W'(LATE_START);

    typedef struct packed {
        logic rd;
        logic cap;
        logic lastbit;
    } brst_t;

    brst_t st_q, st_d;
    logic [CNT_W-1:0] rel, phase, bitn;
    logic             in_burst;

    // relative position of the next cycle inside the burst
    assign rel = t_i + CNT_W'(1) - ((mode_i == RD_LATE) ? L_ST_C : E_ST_C);

    generate
        if (PER2_P2) begin : g_shift
            assign phase = rel & CNT_W'(PER2 - 1);
            assign bitn  = rel >> $clog2(PER2);
        end else begin : g_div
            assign phase = rel % CNT_W'(PER2);
            assign bitn  = rel / CNT_W'(PER2);
        end
    endgenerate

    always_comb begin
        in_burst     = active_i && !wrap_i && (rel < BURST_C);
        st_d.rd      = in_burst && (phase < HALF_C);
        st_d.cap     = in_burst && (phase == CAP_C);
        st_d.lastbit = in_burst && (phase == CAP_C) && (bitn == LASTB_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_clk_o  = st_q.rd;
    assign cap_o     = st_q.cap;
    assign lastbit_o = st_q.lastbit;

endmodule

// File: rtl/adc_rd_deser.sv
// Serial-to-parallel capture, MSB first, with word tag and valid strobe.
module adc_rd_deser
    import adc_rd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              lastbit_i,
    input  logic              sdata_i,
    input  rd_mode_e          mode_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] word_o,
    output logic [IDX_W-1:0]  tag_o,
    output logic              valid_o
);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] word;
        logic [IDX_W-1:0]  tag;
        logic              valid;
    } des_t;

    des_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (cap_i) begin
            st_d.sh = {st_q.sh[DATA_W-2:0], sdata_i};
            if (lastbit_i) begin
                st_d.word  = {st_q.sh[DATA_W-2:0], sdata_i};
                st_d.tag   = (mode_i == RD_LATE) ? idx_i : idx_i - IDX_W'(1);
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o  = st_q.word;
    assign tag_o   = st_q.tag;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 12,
    parameter int IDX_W    = 8,
    parameter int CNV_W    = 2,
    parameter int HALF_CYC = 1,
    parameter int CLKL_CYC = 40,
    parameter int TCLK_PS  = 2000,
    parameter int READY_PS = 145000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              mode_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic              sdata_i,
    output logic              cnv_o,
    output logic              rd_clk_o,
    output logic [DATA_W-1:0] word_o,
    output logic [IDX_W-1:0]  tag_o,
    output logic              valid_o,
    output logic              cfg_err_o
);

    localparam int READY_CYC = int'(ps_to_cyc(READY_PS, TCLK_PS));
    localparam int BURST_CYC = 2 * HALF_CYC * DATA_W;
    localparam int MIN_LATE  = READY_CYC + BURST_CYC;
    localparam int MIN_EARLY = READY_CYC;
    localparam bit EARLY_OK  = ((1 + BURST_CYC) <= CLKL_CYC);

    logic [CNT_W-1:0] t_w;
    logic             wrap_w, active_w, cap_w, lastbit_w;
    rd_mode_e         cur_mode_w;
    logic [IDX_W-1:0] idx_w;

    adc_rd_seq #(
        .CNT_W(CNT_W), .IDX_W(IDX_W), .CNV_W(CNV_W),
        .MIN_EARLY(MIN_EARLY), .MIN_LATE(MIN_LATE), .EARLY_OK(EARLY_OK)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
        .mode_i(rd_mode_e'(mode_i)), .period_i(period_i),
        .t_o(t_w), .wrap_o(wrap_w), .active_o(active_w), .mode_o(cur_mode_w),
        .idx_o(idx_w), .cnv_o(cnv_o), .cfg_err_o(cfg_err_o)
    );

    adc_rd_burst #(
        .CNT_W(CNT_W), .DATA_W(DATA_W), .HALF_CYC(HALF_CYC),
        .EARLY_START(1), .LATE_START(READY_CYC)
    ) u_burst (
        .clk(clk), .rst_n(rst_n), .t_i(t_w), .wrap_i(wrap_w),
        .active_i(active_w), .mode_i(cur_mode_w),
        .rd_clk_o(rd_clk_o), .cap_o(cap_w), .lastbit_o(lastbit_w)
    );

    adc_rd_deser #(
        .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_deser (
        .clk(clk), .rst_n(rst_n), .cap_i(cap_w), .lastbit_i(lastbit_w),
        .sdata_i(sdata_i), .mode_i(cur_mode_w), .idx_i(idx_w),
        .word_o(word_o), .tag_o(tag_o), .valid_o(valid_o)
    );

endmodule

// File: rtl/adc_readout_ctrl_chk.sv
module adc_readout_ctrl_chk #(
    parameter int CNT_W     = 12,
    parameter int DATA_W    = 16,
    parameter int CNV_W     = 2,
    parameter int CLKL_CYC  = 40,
    parameter int READY_CYC = 73
) (
    input logic clk,
    input logic rst_n,
    input logic cnv,
    input logic rd_clk,
    input logic valid,
    input logic cfg_err
);

    localparam int RC_W = $clog2(DATA_W + 2) + 1;
    localparam logic [CNT_W-1:0] QS_C = CNT_W'(CLKL_CYC);
    localparam logic [CNT_W-1:0] QE_C = CNT_W'(READY_CYC);
    localparam logic [RC_W-1:0]  NB_C = RC_W'(DATA_W);

    logic             cnv_p, rd_p, seen_q;
    logic [CNT_W-1:0] tc_q, tc_now;
    logic [RC_W-1:0]  rc_q, rc_now;
    logic [CNT_W-1:0] hi_q;
    logic             cnv_rise, rd_rise;

    assign cnv_rise = cnv && !cnv_p;
    assign rd_rise  = rd_clk && !rd_p;
    assign tc_now   = cnv_rise ? '0 : ((&tc_q) ? tc_q : tc_q + CNT_W'(1));
    assign rc_now   = cnv_rise ? '0 : rc_q + RC_W'(rd_rise);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_p  <= 1'b0;
            rd_p   <= 1'b0;
            seen_q <= 1'b0;
            tc_q   <= '0;
            rc_q   <= '0;
            hi_q   <= '0;
        end else begin
            cnv_p  <= cnv;
            rd_p   <= rd_clk;
            seen_q <= seen_q | cnv_rise;
            tc_q   <= tc_now;
            rc_q   <= rc_now;
            hi_q   <= cnv ? hi_q + CNT_W'(1) : '0;
        end
    end

    // R2: no read clock rise inside the quiet window
    assert_quiet_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rise && (seen_q || cnv_rise)) |-> !((tc_now >= QS_C) && (tc_now < QE_C)));

    // R1: conversion strobe width
    assert_cnv_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv) |-> (hi_q == CNT_W'(CNV_W)));

    // R3: a burst never exceeds the word length in rising edges
    assert_burst_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rise |-> (rc_now <= NB_C));

    // R6: valid is a single-cycle pulse
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6: valid only after all bits of the burst were clocked
    assert_valid_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (rc_now == NB_C));

    // R8: no conversion start while configuration misfits
    assert_cfg_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv) |-> !cfg_err);

endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .CNV_W(CNV_W),
    .CLKL_CYC(CLKL_CYC), .READY_CYC(READY_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cnv(cnv_o), .rd_clk(rd_clk_o),
    .valid(valid_o), .cfg_err(cfg_err_o)
);

// File: tb/adc_readout_ctrl_bench.sv
module adc_readout_ctrl_bench;

    localparam int DW    = 16;
    localparam int CW    = 12;
    localparam int IW    = 8;
    localparam int CNVW  = 2;
    localparam int H     = 1;
    localparam int CLKL  = 40;
    localparam int READY = (145000 + 2000 - 1) / 2000;   // 73
    localparam int BURST = 2 * H * DW;
    localparam int CAPO  = H / 2;
    localparam int VREL  = BURST - 2 * H + CAPO + 1;     // valid offset from burst start

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, mode = 1'b0, sdata = 1'b0;
    logic [CW-1:0] per = CW'(105);
    logic cnv, rdc, valid, cerr;
    logic [DW-1:0] word;
    logic [IW-1:0] tag;

    always #5 clk = ~clk;

    adc_readout_ctrl #(
        .DATA_W(DW), .CNT_W(CW), .IDX_W(IW), .CNV_W(CNVW), .HALF_CYC(H),
        .CLKL_CYC(CLKL), .TCLK_PS(2000), .READY_PS(145000)
    ) u_adc_readout_ctrl (
        .clk(clk), .rst_n(rst_n), .enable_i(en), .mode_i(mode), .period_i(per),
        .sdata_i(sdata), .cnv_o(cnv), .rd_clk_o(rdc), .word_o(word), .tag_o(tag),
        .valid_o(valid), .cfg_err_o(cerr)
    );

    int total = 0, bad = 0;
    int unsigned salt;
    bit finished = 1'b0;

    function automatic logic [15:0] val(input logic [7:0] i, input int unsigned s);
        logic [15:0] v;
        v = {8'h00, i} * 16'd40503;
        return v ^ s[15:0];
    endfunction

    function automatic bit fits(input logic m, input int p);
        if (m) return p >= READY + BURST;
        return (p >= READY) && (1 + BURST <= CLKL);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected-behaviour model
    bit m_busy; int m_t, m_p, m_cur, m_nxt; logic m_mode;
    // converter model
    bit a_cnvp, a_rdp; int a_tc, a_k, a_bits, a_gap, last_vtc;
    logic [15:0] a_word;
    int cnv_cnt, val_cnt, first_tag;

    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            m_busy = 0; m_t = 0; m_p = 0; m_cur = 0; m_nxt = 0; m_mode = 0;
            a_cnvp = 0; a_rdp = 0; a_tc = 0; a_k = -1; a_bits = 0; a_gap = 0;
            a_word = '0; last_vtc = -1; cnv_cnt = 0; val_cnt = 0; first_tag = -1;
        end else begin
            bit st, e_rd, e_val, e_cnv;
            int rel;
            logic [7:0] e_tag;
            st = (!m_busy || m_t == m_p - 1) && en && fits(mode, int'(per));
            if (st) begin
                m_busy = 1; m_t = 0; m_p = int'(per); m_mode = mode;
                m_cur = m_nxt; m_nxt++;
            end else if (m_busy && m_t == m_p - 1) begin
                m_busy = 0; m_t = 0;
            end else if (m_busy) m_t++;

            rel   = m_t - (m_mode ? READY : 1);
            e_cnv = m_busy && m_t < CNVW;
            e_rd  = m_busy && rel >= 0 && rel < BURST && (rel % (2 * H)) < H;
            e_val = m_busy && rel == VREL;
            e_tag = m_mode ? 8'(m_cur) : 8'(m_cur - 1);

            chk(cnv == e_cnv, "R1", "cnv_o", cnv, e_cnv);
            chk(rdc == e_rd, m_mode ? "R3" : "R4", "rd_clk_o", rdc, e_rd);
            chk(cerr == !fits(mode, int'(per)), "R8", "cfg_err_o", cerr, !fits(mode, int'(per)));
            chk(valid == e_val, "R6", "valid_o", valid, e_val);
            if (valid && e_val) begin
                chk(tag == e_tag, "R7", "tag_o", tag, e_tag);
                chk(word == val(e_tag, salt), "R5", "word_o", word, val(e_tag, salt));
            end

            // converter model driven by the actual pins
            if (cnv && !a_cnvp) begin
                a_gap = a_tc + 1; a_tc = 0; a_k++; a_bits = 0; cnv_cnt++;
            end else a_tc++;
            if (valid) begin
                last_vtc = a_tc; val_cnt++;
                if (first_tag < 0) first_tag = int'(tag);
            end
            if (rdc && !a_rdp) begin
                chk(!(a_tc >= CLKL && a_tc < READY), "R2", "rise in quiet window", a_tc, CLKL);
                if (a_bits == 0) begin
                    if (a_tc < CLKL)       a_word = val(8'(a_k - 1), salt);
                    else if (a_tc >= READY) a_word = val(8'(a_k), salt);
                    else                    a_word = 16'h0BAD;
                end
                if (a_bits < 16) sdata = a_word[15 - a_bits];
                a_bits++;
            end
            a_cnvp = cnv; a_rdp = rdc;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic wait_cnv();
        int c0 = cnv_cnt;
        for (int i = 0; i < 2000 && cnv_cnt == c0; i++) step(1);
    endtask

    task automatic wait_val();
        int v0 = val_cnt;
        for (int i = 0; i < 2000 && val_cnt == v0; i++) step(1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        int c0, v0;
        void'($urandom(32'd7321));
        salt = $urandom;

        // R11: reset state
        step(4);
        chk(!cnv && !rdc && !valid && !cerr, "R11", "control outputs in reset",
            {cnv, rdc, valid, cerr}, 0);
        chk(word == '0 && tag == '0, "R11", "word/tag in reset", {word, tag}, 0);
        rst_n = 1'b1;

        // early mode at its minimum period; first tag wraps to 255
        mode = 1'b0; per = CW'(READY); en = 1'b1;
        step(5 * READY);
        chk(first_tag == 255, "R7", "first early tag", first_tag, 255);

        // early mode one below minimum
        per = CW'(READY - 1);
        step(2 * READY);
        c0 = cnv_cnt; step(150);
        chk(cerr == 1'b1, "R8", "cfg_err early short", cerr, 1);
        chk(cnv_cnt == c0, "R8", "no start while misfit", cnv_cnt, c0);

        // late mode at its minimum and one below
        mode = 1'b1; per = CW'(READY + BURST);
        step(5 * (READY + BURST));
        per = CW'(READY + BURST - 1);
        step(2 * (READY + BURST));
        c0 = cnv_cnt; step(150);
        chk(cerr == 1'b1 && cnv_cnt == c0, "R8", "late misfit blocks start", cnv_cnt, c0);

        // R9: mid-period change of mode and period is deferred
        per = CW'(READY + BURST);
        wait_cnv(); step(5);
        mode = 1'b0; per = CW'(300);
        wait_val();
        chk(last_vtc == READY + VREL, "R9", "valid position after mid-period change",
            last_vtc, READY + VREL);
        wait_cnv();
        chk(a_gap == READY + BURST, "R9", "period length after mid-period change",
            a_gap, READY + BURST);
        step(400);

        // R10: enable drop mid-period lets the running period finish
        mode = 1'b1; per = CW'(120);
        wait_cnv(); step(3);
        en = 1'b0; c0 = cnv_cnt; v0 = val_cnt;
        step(300);
        chk(val_cnt == v0 + 1, "R10", "burst completes after disable", val_cnt, v0 + 1);
        chk(cnv_cnt == c0, "R10", "no start while disabled", cnv_cnt, c0);

        // constrained random segments
        for (int s = 0; s < 220; s++) begin
            en   = ($urandom % 8) != 0;
            mode = 1'($urandom % 2);
            per  = CW'(60 + ($urandom % 160));
            step(20 + int'($urandom % 300));
        end
        en = 1'b0;
        step(400);
        finish_run();
    end

endmodule